// File: doc/BRIEF.md
# Interlaced Field Write-Address Generator

This block produces the memory write addresses for captured pixel data arriving as an interlaced video stream. Each field parity (even and odd) owns a set of three plane pointers: plane 0 holds luma or packed RGB data, plane 1 holds U and plane 2 holds V. Every plane has a programmable start address and a programmable line skip. Each parity also has an upper buffer limit. The pixel path delivers one 32-bit word per write strobe, with a plane select and an end-of-line marker. A field-start pulse, qualified by the parity input, reloads all three pointers of that parity.

For packed formats only plane 0 is used. The odd-field start is placed one line of bytes above the even-field start, and the skip equals one line, so the two fields interleave in a single frame buffer. For planar YUV with N = rows × columns and base B, the even planes start at B, B+N and B+N+N/4. The odd planes start at B+columns, B+N+N/2 and B+N+N/2+N/4, and every skip equals the column count. Software computes these values and writes them through a small configuration port. The block adds the same values in hardware at each line end.

A write whose address reaches that parity's limit is dropped, and a sticky error flag for the parity is raised.

Top module: `field_dma_agen`

## Requirements
- R1: While reset is applied, and until the first pixel write after reset, `wr_en`, `addr_err_even` and `addr_err_odd` are 0. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R2: A configuration write with `cfg_we`=1 stores `cfg_wdata` in the register selected by `cfg_idx`. Bit 3 of the index selects parity (1 = odd). Bits 2:0 select the register: 0–2 are plane 0–2 start, 3–5 are plane 0–2 skip, 6 is the limit, and 7 selects nothing. Plane 0 start stores bit 0 as zero. Plane 1 and 2 starts store bits 1:0 as zero. A skip keeps 16 bits with bits 1:0 zero. The limit keeps 24 bits with bits 1:0 zero.
- R3: `field_start`=1 latches `field_odd` as the current parity and loads all three plane pointers from that parity's start registers. Any `pix_we` or `pix_eol` in the same cycle is ignored.
- R4: A pixel write (`pix_we`=1, `pix_plane` 0–2) presents the selected plane's pointer on `wr_addr` with `wr_en`=1 in the following cycle. That pointer then advances by 4 bytes, and the other planes do not move.
- R5: `pix_eol`=1 for a plane sets its pointer to the address after the last word of the line plus the current parity's skip for that plane. A write in the same cycle still uses the old address, so the new pointer is old+4+skip. Without a write it is old+skip.
- R6: A write whose address is greater than or equal to the current parity's limit gives `wr_en`=0 and sets that parity's error flag in the following cycle. The pointer still advances.
- R7: An error flag stays set until a configuration write to the limit register of the same parity clears it.
- R8: `pix_plane`=3 selects no plane. A write or line end with it produces no `wr_en` and moves no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| field_start | input | 1 | Start of a new field |
| field_odd | input | 1 | Parity of the starting field (1 = odd) |
| pix_we | input | 1 | One 32-bit pixel word to store |
| pix_plane | input | 2 | Plane of the word or line end |
| pix_eol | input | 1 | Last word / end of line for the plane |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | 24 | Byte address of the write |
| addr_err_even | output | 1 | Sticky limit error, even field |
| addr_err_odd | output | 1 | Sticky limit error, odd field |

## Verification
The bench targets the line-end cases first. A line end together with a write must use the old address and then skip past it, so a design that applied the skip first would write a line early. A line end alone must not add the word step. The bench also checks that plane pointers are independent under interleaved planar writes, and that the odd field uses its own starts and skips; a shared pointer would corrupt the U and V planes. At the limit the bench checks that a write exactly at the limit is dropped, not just writes beyond it, and that the error flag stays with its parity and survives until its limit register is rewritten. It also checks that a field start arriving together with a write drops the write, and that writes to plane 3 move nothing.

// File: rtl/field_dma_pkg.sv
package field_dma_pkg;
  localparam int NPLANE  = 3;
  localparam int NPAR    = 2;
  localparam int IDX_W   = 4;
  localparam int CFG_W   = 32;
  localparam int WORD_BY = 4;

  // register selector within one parity (cfg_idx[2:0])
  typedef enum logic [2:0] {
    SEL_START0  = 3'd0,
    SEL_START1  = 3'd1,
    SEL_START2  = 3'd2,
    SEL_SKIP0   = 3'd3,
    SEL_SKIP1   = 3'd4,
    SEL_SKIP2   = 3'd5,
    SEL_LIMIT   = 3'd6,
    SEL_NONE    = 3'd7
  } cfg_sel_e;

  function automatic cfg_sel_e start_sel(input int plane);
    return cfg_sel_e'(3'(plane));
  endfunction

  function automatic cfg_sel_e skip_sel(input int plane);
    return cfg_sel_e'(3'(plane + 3));
  endfunction
endpackage

// File: rtl/field_dma_regs.sv
module field_dma_regs
  import field_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SKIP_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [IDX_W-1:0]                       cfg_idx,
  input  logic [CFG_W-1:0]                       cfg_wdata,
  output logic [NPAR-1:0][NPLANE-1:0][ADDR_W-1:0] start_o,
  output logic [NPAR-1:0][NPLANE-1:0][SKIP_W-1:0] skip_o,
  output logic [NPAR-1:0][ADDR_W-1:0]             limit_o,
  output logic [NPAR-1:0]                         limit_wr_o
);
  logic [CFG_W-1:0] unused_wdata;
  assign unused_wdata = cfg_wdata;

  cfg_sel_e sel;
  logic     par;
  assign sel = cfg_sel_e'(cfg_idx[2:0]);
  assign par = cfg_idx[3];

  // aligned forms of the write data
  logic [ADDR_W-1:0] wd_half, wd_word;
  logic [SKIP_W-1:0] wd_skip;
  assign wd_half = {cfg_wdata[ADDR_W-1:1], 1'b0};
  assign wd_word = {cfg_wdata[ADDR_W-1:2], 2'b00};
  assign wd_skip = {cfg_wdata[SKIP_W-1:2], 2'b00};

  for (genvar p = 0; p < NPAR; p++) begin : g_par
    logic par_hit;
    assign par_hit = cfg_we && (par == 1'(p));

    for (genvar k = 0; k < NPLANE; k++) begin : g_plane
      logic              st_en, sk_en;
      logic [ADDR_W-1:0] st_q, st_d;
      logic [SKIP_W-1:0] sk_q, sk_d;

      always_comb begin
        st_en = par_hit && (sel == start_sel(k));
        sk_en = par_hit && (sel == skip_sel(k));
        st_d  = (k == 0) ? wd_half : wd_word;
        sk_d  = wd_skip;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= '0;
        else if (st_en) st_q <= st_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sk_q <= '0;
        else if (sk_en) sk_q <= sk_d;
      end

      assign start_o[p][k] = st_q;
      assign skip_o[p][k]  = sk_q;
    end

    logic              lim_en;
    logic [ADDR_W-1:0] lim_q;
    assign lim_en = par_hit && (sel == SEL_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lim_q <= '0;
      else if (lim_en) lim_q <= wd_word;
    end

    assign limit_o[p]    = lim_q;
    assign limit_wr_o[p] = lim_en;
  end
endmodule

// File: rtl/field_dma_ptr.sv
module field_dma_ptr
  import field_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              eol,
  input  logic [SKIP_W-1:0] skip,
  output logic [ADDR_W-1:0] cur_o
);
  localparam logic [ADDR_W-1:0] STEP_INC = ADDR_W'(WORD_BY);

  logic [ADDR_W-1:0] cur_q, cur_d, after_word;
  logic              en;

  always_comb begin
    after_word = step ? (cur_q + STEP_INC) : cur_q;
    en         = load | step | eol;
    if (load)     cur_d = load_addr;
    else if (eol) cur_d = after_word + ADDR_W'(skip);
    else          cur_d = after_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_q <= '0;
    else if (en) cur_q <= cur_d;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/field_dma_limit.sv
module field_dma_limit #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk,
  input  logic              par_odd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] limit,
  input  logic [1:0]        clr,
  output logic              over_o,
  output logic              err_even_o,
  output logic              err_odd_o
);
  logic over;
  logic err_even_q, err_even_d, err_odd_q, err_odd_d;

  always_comb begin
    over       = addr >= limit;
    err_even_d = err_even_q;
    err_odd_d  = err_odd_q;
    if (clr[0]) err_even_d = 1'b0;
    if (clr[1]) err_odd_d  = 1'b0;
    if (chk && over && !par_odd) err_even_d = 1'b1;
    if (chk && over &&  par_odd) err_odd_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_even_q <= 1'b0;
      err_odd_q  <= 1'b0;
    end else begin
      err_even_q <= err_even_d;
      err_odd_q  <= err_odd_d;
    end
  end

  assign over_o     = over;
  assign err_even_o = err_even_q;
  assign err_odd_o  = err_odd_q;
endmodule

// File: rtl/field_dma_agen.sv
module field_dma_agen
  import field_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              field_start,
  input  logic              field_odd,
  input  logic              pix_we,
  input  logic [1:0]        pix_plane,
  input  logic              pix_eol,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              addr_err_even,
  output logic              addr_err_odd
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NPAR-1:0][NPLANE-1:0][ADDR_W-1:0] start_r;
  logic [NPAR-1:0][NPLANE-1:0][SKIP_W-1:0] skip_r;
  logic [NPAR-1:0][ADDR_W-1:0]             limit_r;
  logic [NPAR-1:0]                         limit_wr;

  field_dma_regs #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .start_o    (start_r),
    .skip_o     (skip_r),
    .limit_o    (limit_r),
    .limit_wr_o (limit_wr)
  );

  // current field parity
  logic cur_odd_q, cur_odd_d;
  always_comb cur_odd_d = field_start ? field_odd : cur_odd_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cur_odd_q <= 1'b0;
    else             cur_odd_q <= cur_odd_d;
  end

  // qualified pixel events
  logic plane_ok, accept, eol_ok;
  always_comb begin
    plane_ok = pix_plane < 2'(NPLANE);
    accept   = pix_we  && !field_start && plane_ok;
    eol_ok   = pix_eol && !field_start && plane_ok;
  end

  logic [NPLANE-1:0][ADDR_W-1:0] cur_addr;

  for (genvar k = 0; k < NPLANE; k++) begin : g_ptr
    logic              hit;
    logic [ADDR_W-1:0] ld_addr;
    assign hit     = pix_plane == 2'(k);
    assign ld_addr = field_odd ? start_r[1][k] : start_r[0][k];

    field_dma_ptr #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .load      (field_start),
      .load_addr (ld_addr),
      .step      (accept && hit),
      .eol       (eol_ok && hit),
      .skip      (cur_odd_q ? skip_r[1][k] : skip_r[0][k]),
      .cur_o     (cur_addr[k])
    );
  end

  logic [ADDR_W-1:0] sel_addr, limit_sel;
  always_comb begin
    sel_addr  = plane_ok ? cur_addr[pix_plane] : '0;
    limit_sel = cur_odd_q ? limit_r[1] : limit_r[0];
  end

  logic over;
  field_dma_limit #(.ADDR_W(ADDR_W)) u_limit (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .chk        (accept),
    .par_odd    (cur_odd_q),
    .addr       (sel_addr),
    .limit      (limit_sel),
    .clr        (limit_wr),
    .over_o     (over),
    .err_even_o (addr_err_even),
    .err_odd_o  (addr_err_odd)
  );

  // output stage
  logic              wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] wr_addr_q;
  always_comb wr_en_d = accept && !over;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_en_q <= 1'b0;
    else             wr_en_q <= wr_en_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  wr_addr_q <= '0;
    else if (accept)  wr_addr_q <= sel_addr;
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
endmodule

// File: rtl/field_dma_agen_chk.sv
module field_dma_agen_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cfg_we,
  input logic [3:0]        cfg_idx,
  input logic              field_start,
  input logic              pix_we,
  input logic [1:0]        pix_plane,
  input logic              cur_odd_q,
  input logic [ADDR_W-1:0] limit_sel,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              addr_err_even,
  input logic              addr_err_odd
);
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      assert_rst_quiet_R1: assert (!wr_en && !addr_err_even && !addr_err_odd);
    end
  end

  assert_fs_drops_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    field_start |=> !wr_en);

  assert_wr_cause_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> $past(pix_we && !field_start));

  assert_below_limit_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (wr_addr < $past(limit_sel)));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(addr_err_odd) |-> $past(pix_we && cur_odd_q));

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_err_even && !(cfg_we && cfg_idx == 4'd6)) |=> addr_err_even);

  assert_no_plane3_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_we && pix_plane == 2'd3) |=> !wr_en);
endmodule

bind field_dma_agen field_dma_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .cfg_we        (cfg_we),
  .cfg_idx       (cfg_idx),
  .field_start   (field_start),
  .pix_we        (pix_we),
  .pix_plane     (pix_plane),
  .cur_odd_q     (cur_odd_q),
  .limit_sel     (limit_sel),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .addr_err_even (addr_err_even),
  .addr_err_odd  (addr_err_odd)
);

// File: tb/field_dma_agen_bench.sv
module field_dma_agen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        field_start = 1'b0;
  logic        field_odd = 1'b0;
  logic        pix_we = 1'b0;
  logic [1:0]  pix_plane = '0;
  logic        pix_eol = 1'b0;
  logic        wr_en;
  logic [23:0] wr_addr;
  logic        addr_err_even, addr_err_odd;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_dma_agen u_field_dma_agen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .field_start(field_start), .field_odd(field_odd),
    .pix_we(pix_we), .pix_plane(pix_plane), .pix_eol(pix_eol),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .addr_err_even(addr_err_even), .addr_err_odd(addr_err_odd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fstart(input logic odd, input logic with_wr);
    @(negedge clk);
    field_start = 1'b1; field_odd = odd; pix_we = with_wr; pix_plane = 2'd0;
    @(negedge clk);
    if (with_wr) chk(wr_en == 1'b0, "R3 write with field start", 32'(wr_en), 32'd0);
    field_start = 1'b0; pix_we = 1'b0;
  endtask

  // one pixel event; checks wr_en and, when enabled, wr_addr one cycle later
  task automatic pix(input logic we, input logic [1:0] pl, input logic eol,
                     input logic exp_en, input logic [23:0] exp_a, input string req);
    @(negedge clk);
    pix_we = we; pix_plane = pl; pix_eol = eol;
    @(negedge clk);
    chk(wr_en == exp_en, {req, " wr_en"}, 32'(wr_en), 32'(exp_en));
    if (exp_en) chk(wr_addr == exp_a, {req, " wr_addr"}, 32'(wr_addr), 32'(exp_a));
    pix_we = 1'b0; pix_eol = 1'b0; pix_plane = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!wr_en && !addr_err_even && !addr_err_odd, "R1 outputs in reset",
        {29'd0, wr_en, addr_err_even, addr_err_odd}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_en && !addr_err_even && !addr_err_odd, "R1 outputs after release",
        {29'd0, wr_en, addr_err_even, addr_err_odd}, 32'd0);
  endtask

  // packed RGB16, 8 columns: line = 16 bytes, odd field one line up
  task automatic t_packed;
    cfg(4'd6,  32'h0001_0000);  cfg(4'd14, 32'h0001_0000);
    cfg(4'd0,  32'h0000_1000);  cfg(4'd3,  32'd16);
    cfg(4'd8,  32'h0000_1010);  cfg(4'd11, 32'd16);
    fstart(1'b0, 1'b0);
    pix(1, 0, 0, 1, 24'h1000, "R4 even word 0");
    pix(1, 0, 0, 1, 24'h1004, "R4 even word 1");
    pix(1, 0, 0, 1, 24'h1008, "R4 even word 2");
    pix(1, 0, 1, 1, 24'h100C, "R5 eol write uses old address");
    pix(1, 0, 0, 1, 24'h1020, "R5 even next line skips odd line");
    fstart(1'b1, 1'b0);
    pix(1, 0, 0, 1, 24'h1010, "R3 odd field start");
    pix(1, 0, 1, 1, 24'h1014, "R4 odd word 1");
    pix(1, 0, 0, 1, 24'h1028, "R5 odd next line");
  endtask

  // planar YUV, 8 x 4, N = 32, base 0x4000
  task automatic t_planar;
    cfg(4'd0, 32'h4000); cfg(4'd1, 32'h4020); cfg(4'd2, 32'h4028);
    cfg(4'd8, 32'h4008); cfg(4'd9, 32'h4030); cfg(4'd10, 32'h4038);
    for (int i = 0; i < 3; i++) begin
      cfg(4'(3 + i), 32'd8);
      cfg(4'(11 + i), 32'd8);
    end
    fstart(1'b0, 1'b0);
    pix(1, 0, 0, 1, 24'h4000, "R4 planar Y");
    pix(1, 1, 0, 1, 24'h4020, "R4 planar U");
    pix(1, 2, 0, 1, 24'h4028, "R4 planar V");
    pix(1, 0, 1, 1, 24'h4004, "R4 Y independent of U V");
    pix(1, 0, 0, 1, 24'h4010, "R5 Y next line");
    pix(1, 1, 0, 1, 24'h4024, "R4 U unaffected by Y eol");
    fstart(1'b1, 1'b0);
    pix(1, 0, 0, 1, 24'h4008, "R3 odd Y start");
    pix(1, 2, 0, 1, 24'h4038, "R3 odd V start");
    pix(1, 1, 0, 1, 24'h4030, "R3 odd U start");
    pix(1, 3, 0, 0, 24'h0,    "R8 plane 3 write");
    pix(0, 3, 1, 0, 24'h0,    "R8 plane 3 eol");
    pix(1, 2, 0, 1, 24'h403C, "R8 V untouched by plane 3");
    pix(1, 0, 0, 1, 24'h400C, "R8 Y untouched by plane 3");
  endtask

  task automatic t_eol_only;
    cfg(4'd0, 32'h1000); cfg(4'd3, 32'd16);
    fstart(1'b0, 1'b0);
    pix(0, 0, 1, 0, 24'h0,    "R5 eol without write");
    pix(1, 0, 0, 1, 24'h1010, "R5 eol alone adds skip only");
    pix(1, 0, 0, 1, 24'h1014, "R4 after eol");
    fstart(1'b0, 1'b1);
    pix(1, 0, 0, 1, 24'h1000, "R3 reload after mid-line restart");
  endtask

  task automatic t_masks;
    cfg(4'd0, 32'hFF00_2001);  // plane 0 start, bit 0 dropped
    cfg(4'd1, 32'h0000_3003);  // plane 1 start, bits 1:0 dropped
    cfg(4'd3, 32'h0005_0007);  // plane 0 skip: 16 bits, bits 1:0 dropped -> 4
    cfg(4'd7, 32'h0000_0100);  // selects nothing
    fstart(1'b0, 1'b0);
    pix(1, 0, 1, 1, 24'h2000, "R2 plane 0 start bit 0");
    pix(1, 0, 0, 1, 24'h2008, "R2 skip masked to 16 bits aligned");
    pix(1, 1, 0, 1, 24'h3000, "R2 plane 1 start bits 1:0");
  endtask

  task automatic t_limit;
    cfg(4'd0, 32'h1000); cfg(4'd6, 32'h100B);  // limit stored as 0x1008
    fstart(1'b0, 1'b0);
    pix(1, 0, 0, 1, 24'h1000, "R6 below limit");
    pix(1, 0, 0, 1, 24'h1004, "R6 last word below limit");
    chk(addr_err_even == 1'b0, "R6 no error yet", 32'(addr_err_even), 32'd0);
    pix(1, 0, 0, 0, 24'h0, "R6 write at limit dropped");
    chk(addr_err_even == 1'b1, "R6 even error set", 32'(addr_err_even), 32'd1);
    chk(addr_err_odd == 1'b0, "R6 odd error untouched", 32'(addr_err_odd), 32'd0);
    pix(1, 0, 0, 0, 24'h0, "R6 write beyond limit dropped");
    cfg(4'd14, 32'h0001_0000);
    chk(addr_err_even == 1'b1, "R7 odd limit write keeps even error",
        32'(addr_err_even), 32'd1);
    cfg(4'd6, 32'h0001_0000);
    chk(addr_err_even == 1'b0, "R7 even limit write clears", 32'(addr_err_even), 32'd0);
    pix(1, 0, 0, 1, 24'h1010, "R6 pointer advanced over dropped writes");
  endtask

  initial begin
    t_reset();
    t_packed();
    t_planar();
    t_eol_only();
    t_masks();
    t_limit();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule